// File: doc/BRIEF.md
# Multi-Input Wake-Up Controller

This block monitors a group of general-purpose input pins and records wake-up events on them. Each pin goes through a two-flop synchronizer. Each pin also has its own polarity bit that selects which edge counts as an event. When the selected edge arrives, a sticky per-pin pending flag is set. The flag is set whether or not the pin is enabled. Only a write-one-to-clear access from software clears it.

Three pin-wide registers hold the state: polarity, enable and pending. Software reaches them, and a control register, through a simple synchronous register bus. A pin whose enable bit and pending bit are both 1 raises the wake output. While such a pin exists, the block also refuses a request to enter the halted state. The halted flag is set when a halt request is accepted. It clears as soon as an enabled pending pin exists.

Top module: `mwu_ctrl`

## Requirements
- R1: After reset the polarity, enable and pending registers read as zero, and `halted_o` and `wake_o` are low.
- R2: Polarity bit 0 makes a rising edge of the synchronized pin set that pin's pending bit. Polarity bit 1 makes a falling edge set it. The other edge leaves the bit unchanged.
- R3: A pending bit is set by its selected edge even when the pin's enable bit is 0.
- R4: A pending bit stays set until software clears it.
- R5: Writing address 2 clears every pending bit whose write-data bit is 1 and leaves the other pending bits unchanged.
- R6: If a clearing write and a new selected edge hit the same pending bit in the same cycle, the bit ends up set.
- R7: `wake_o` is high exactly one cycle after the AND of the enable and pending registers is nonzero.
- R8: A write to address 3 with data bit 0 set is ignored while any pin is both enabled and pending.
- R9: An accepted halt request sets `halted_o` on the next cycle. The flag clears on the cycle after any pin becomes both enabled and pending.
- R10: Register map: address 0 is polarity, address 1 is enable, address 2 is pending, and address 3 reads {wake in bit 1, halted in bit 0}. A read returns its data on `rd_data` one cycle after the address is presented. Address 0 and address 1 are read/write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | NPINS | Asynchronous wake-up input pins |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | NPINS | Write data |
| rd_data | output | NPINS | Registered read data |
| wake_o | output | 1 | Wake-up request |
| halted_o | output | 1 | Halted state flag |

## Verification
On every cycle, the assertions check the following: the reset state, that pending bits fall only under a matching clearing write, that a halt request is refused while a wake source is active, and that the halted flag is released when a source appears. Only the bench scenarios can show that each polarity selects the right edge, that a disabled pin still latches, and that a set arriving in the same cycle as a clear wins. The same applies to the pipeline latency from pin to pending to wake. A behavioural model in the bench tracks all outputs on every cycle.

// File: rtl/mwu_pkg.sv
package mwu_pkg;
  typedef enum logic [1:0] {
    REG_POL  = 2'd0,
    REG_EN   = 2'd1,
    REG_PEND = 2'd2,
    REG_CTRL = 2'd3
  } mwu_reg_e;
endpackage

// File: rtl/mwu_sync.sv
module mwu_sync #(
  parameter int W = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mwu_pin_cell.sv
module mwu_pin_cell (
  input  logic clk,
  input  logic rst,
  input  logic smp,
  input  logic fall_sel,
  input  logic clr,
  output logic pend
);
  logic prev;
  logic hit;

  assign hit = fall_sel ? (prev & ~smp) : (smp & ~prev);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= 1'b0;
      pend <= 1'b0;
    end else begin
      prev <= smp;
      pend <= (pend & ~clr) | hit;
    end
  end
endmodule

// File: rtl/mwu_halt_gate.sv
module mwu_halt_gate (
  input  logic clk,
  input  logic rst,
  input  logic halt_req,
  input  logic active,
  output logic halted,
  output logic wake
);
  always_ff @(posedge clk) begin
    if (rst) begin
      halted <= 1'b0;
      wake   <= 1'b0;
    end else begin
      wake <= active;
      if (active)        halted <= 1'b0;
      else if (halt_req) halted <= 1'b1;
    end
  end
endmodule

// File: rtl/mwu_ctrl.sv
module mwu_ctrl #(
  parameter int NPINS = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pins_i,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] rd_data,
  output logic             wake_o,
  output logic             halted_o
);
  import mwu_pkg::*;

  logic [NPINS-1:0] pol_q, en_q, pend_q, smp, clr_vec;
  logic             active, halt_req;
  mwu_reg_e         sel;

  assign sel      = mwu_reg_e'(bus_addr);
  assign clr_vec  = (bus_wr && sel == REG_PEND) ? bus_wdata : '0;
  assign halt_req = bus_wr && sel == REG_CTRL && bus_wdata[0];
  assign active   = |(en_q & pend_q);

  mwu_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pins_i), .q(smp)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    mwu_pin_cell u_cell (
      .clk(clk), .rst(rst), .smp(smp[i]), .fall_sel(pol_q[i]),
      .clr(clr_vec[i]), .pend(pend_q[i])
    );
  end

  mwu_halt_gate u_gate (
    .clk(clk), .rst(rst), .halt_req(halt_req), .active(active),
    .halted(halted_o), .wake(wake_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pol_q   <= '0;
      en_q    <= '0;
      rd_data <= '0;
    end else begin
      if (bus_wr && sel == REG_POL) pol_q <= bus_wdata;
      if (bus_wr && sel == REG_EN)  en_q  <= bus_wdata;
      unique case (sel)
        REG_POL:  rd_data <= pol_q;
        REG_EN:   rd_data <= en_q;
        REG_PEND: rd_data <= pend_q;
        REG_CTRL: rd_data <= {{(NPINS-2){1'b0}}, wake_o, halted_o};
      endcase
    end
  end
endmodule

// File: rtl/mwu_ctrl_chk.sv
module mwu_ctrl_chk #(
  parameter int NPINS = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       bus_addr,
  input logic             bus_wr,
  input logic [NPINS-1:0] bus_wdata,
  input logic [NPINS-1:0] en_q,
  input logic [NPINS-1:0] pend_q,
  input logic             wake_o,
  input logic             halted_o
);
  logic any_live;
  assign any_live = |(en_q & pend_q);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (en_q == '0 && pend_q == '0 && !halted_o && !wake_o));

  assert_pend_drop_needs_clear_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(pend_q) & ~pend_q &
               ~(($past(bus_wr) && $past(bus_addr) == 2'd2) ? $past(bus_wdata) : '0)) == '0));

  assert_halt_refused_R8: assert property (@(posedge clk) disable iff (rst)
    (!halted_o && any_live) |=> !halted_o);

  assert_halt_released_R9: assert property (@(posedge clk) disable iff (rst)
    (halted_o && any_live) |=> !halted_o);

  assert_wake_needs_source_R7: assert property (@(posedge clk) disable iff (rst)
    (!any_live) |=> !wake_o);
endmodule

bind mwu_ctrl mwu_ctrl_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .en_q(en_q), .pend_q(pend_q),
  .wake_o(wake_o), .halted_o(halted_o)
);

// File: tb/mwu_ctrl_test.sv
module mwu_ctrl_test;
  localparam int N = 8;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] pins_i = '0;
  logic [1:0]   bus_addr = '0;
  logic         bus_wr = 1'b0;
  logic [N-1:0] bus_wdata = '0;
  logic [N-1:0] rd_data;
  logic         wake_o, halted_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mwu_ctrl #(.NPINS(N)) uut (
    .clk(clk), .rst(rst), .pins_i(pins_i), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .rd_data(rd_data),
    .wake_o(wake_o), .halted_o(halted_o)
  );

  // behavioural reference model
  int m_s1[N], m_s2[N], m_prev[N], m_pol[N], m_en[N], m_pend[N];
  int m_halted, m_wake, m_rd;

  always @(posedge clk) begin
    int live, nrd;
    live = 0;
    for (int i = 0; i < N; i++) if (m_en[i] && m_pend[i]) live = 1;
    nrd = 0;
    for (int i = 0; i < N; i++) begin
      case (bus_addr)
        2'd0: nrd += m_pol[i] << i;
        2'd1: nrd += m_en[i] << i;
        2'd2: nrd += m_pend[i] << i;
        default: ;
      endcase
    end
    if (bus_addr == 2'd3) nrd = m_halted + 2 * m_wake;
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        m_s1[i] = 0; m_s2[i] = 0; m_prev[i] = 0;
        m_pol[i] = 0; m_en[i] = 0; m_pend[i] = 0;
      end
      m_halted = 0; m_wake = 0; m_rd = 0;
    end else begin
      for (int i = 0; i < N; i++) begin
        int edge_seen;
        edge_seen = m_pol[i] ? (m_prev[i] == 1 && m_s2[i] == 0)
                             : (m_prev[i] == 0 && m_s2[i] == 1);
        if (bus_wr && bus_addr == 2'd2 && bus_wdata[i]) m_pend[i] = 0;
        if (edge_seen) m_pend[i] = 1;
        m_prev[i] = m_s2[i];
        m_s2[i] = m_s1[i];
        m_s1[i] = pins_i[i];
        if (bus_wr && bus_addr == 2'd0) m_pol[i] = bus_wdata[i];
        if (bus_wr && bus_addr == 2'd1) m_en[i] = bus_wdata[i];
      end
      if (live) m_halted = 0;
      else if (bus_wr && bus_addr == 2'd3 && bus_wdata[0]) m_halted = 1;
      m_wake = live;
      m_rd = nrd;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R7 wake_o model", wake_o, m_wake);
      check("R9 halted_o model", halted_o, m_halted);
      check("R10 rd_data model", rd_data, m_rd);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    bus_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin : watchdog
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v;
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, v); check("R1 pol after reset", v, 0);
    rd(2'd1, v); check("R1 en after reset", v, 0);
    rd(2'd2, v); check("R1 pend after reset", v, 0);
    check("R1 wake low", wake_o, 0);
    check("R1 halted low", halted_o, 0);
    // R10 readback
    wr(2'd0, 8'h02);
    rd(2'd0, v); check("R10 pol readback", v, 8'h02);
    // R3 rising edge on disabled pin 0
    pins_i[0] = 1'b1; idle(4);
    rd(2'd2, v); check("R3 pend set while disabled", v, 8'h01);
    check("R7 no wake when disabled", wake_o, 0);
    // R2 pin 1 falling polarity: rise must not set, fall must set
    pins_i[1] = 1'b1; idle(4);
    rd(2'd2, v); check("R2 rise ignored on falling pin", v, 8'h01);
    pins_i[1] = 1'b0; idle(4);
    rd(2'd2, v); check("R2 fall sets pin1", v, 8'h03);
    pins_i[0] = 1'b0; idle(4);
    rd(2'd2, v); check("R2 fall ignored on rising pin", v, 8'h03);
    // R7 enable makes wake
    wr(2'd1, 8'h02); idle(2);
    check("R7 wake asserted", wake_o, 1);
    // R8 halt refused
    wr(2'd3, 8'h01); idle(1);
    check("R8 halt refused", halted_o, 0);
    // R4 sticky
    idle(6);
    rd(2'd2, v); check("R4 pend sticky", v, 8'h03);
    // R5 W1C of pin1 only
    wr(2'd2, 8'h02);
    rd(2'd2, v); check("R5 w1c clears only selected", v, 8'h01);
    idle(1);
    check("R7 wake drops", wake_o, 0);
    // R9 halt accepted then released
    wr(2'd3, 8'h01);
    check("R9 halted set", halted_o, 1);
    pins_i[1] = 1'b1; idle(4);
    check("R9 still halted on wrong edge", halted_o, 1);
    pins_i[1] = 1'b0; idle(5);
    check("R9 halted released", halted_o, 0);
    check("R7 wake on source", wake_o, 1);
    // R6 set beats clear: pin 2 rising, clear in the same cycle
    wr(2'd2, 8'h02);
    pins_i[2] = 1'b1; idle(2);
    wr(2'd2, 8'h04);
    rd(2'd2, v); check("R6 set wins over clear", v, 8'h05);
    wr(2'd2, 8'h04);
    rd(2'd2, v); check("R5 later clear works", v, 8'h01);
    idle(3);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule